// File: doc/BRIEF.md
# Bus Loopback Test Register

This block is a single 32-bit register placed behind a synchronous, memory-style host bus on an FPGA. Host software uses it to prove every data line and every address line of the bus without any other core logic in the path. A read returns the stored value whatever address it carries. A write stores one of two things. At word address zero it stores the write data. At any other address it stores the word address of the write itself.

The host bus has a chip select, a write strobe, an output enable, a 24-bit word address and separate 32-bit input and output data paths. The output path also has an enable for the bidirectional pads. The address is a word address: the host byte address shifted right by two. Bank-select lines are decoded outside this block.

All bus inputs pass through a synchronizer before the block uses them. A write takes effect once per write strobe. It commits on the cycle the synchronized strobe rises while chip select is asserted, and it uses the address and data sampled through the same synchronizer stages.

Top module: `lb_test_reg`

## Requirements
- R1: A synchronous active-high reset clears the stored value to zero, so a read after reset returns 0x00000000.
- R2: A write to word address 0 stores the 32-bit write data. A later read returns it unchanged, including each single-bit (walking-one) pattern on the 32 data lines.
- R3: A write to a non-zero word address ignores the write data. It stores the address zero-extended to 32 bits, so bits 31..24 read as 0. This holds for each single-bit address pattern on the 24 address lines.
- R4: A read returns the stored value regardless of the address presented during the read.
- R5: Holding the write strobe active for many cycles commits exactly one write, using the address and data present at the strobe's rising edge. Changes to address or data while the strobe stays active have no effect.
- R6: A write strobe without chip select asserted leaves the stored value unchanged.
- R7: `bus_rdata_oe` is 1 and `bus_rdata` carries the stored value only while chip select and output enable are both asserted after synchronization. Otherwise `bus_rdata_oe` is 0 and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_we | input | 1 | Write strobe, active high |
| bus_oe | input | 1 | Read output enable, active high |
| bus_addr | input | 24 | Word address (byte address >> 2) |
| bus_wdata | input | 32 | Write data from the host |
| bus_rdata | output | 32 | Read data to the host, 0 when not driven |
| bus_rdata_oe | output | 1 | Enable for the bidirectional data pads |

## Verification
The hardest case to reach from the ports is a write strobe held active across many cycles while the address and data under it change. A broken edge detector would then commit again, or commit late, and the result would look like an ordinary write. The bench holds the strobe high and swaps both the data and the address, from zero to non-zero, partway through. It then releases the strobe and reads the register back. The readback must show only the value captured when the strobe first rose.

// File: rtl/lb_pkg.sv
package lb_pkg;
    localparam int unsigned LB_DATA_W = 32;
    localparam int unsigned LB_ADDR_W = 24;

    typedef logic [LB_DATA_W-1:0] lb_word_t;
    typedef logic [LB_ADDR_W-1:0] lb_addr_t;

    // One sampled view of the host bus
    typedef struct packed {
        logic     cs;
        logic     we;
        logic     oe;
        lb_addr_t addr;
        lb_word_t data;
    } lb_bus_t;

    // What a committed write stores
    typedef enum logic {
        LB_SRC_DATA = 1'b0,
        LB_SRC_ADDR = 1'b1
    } lb_src_e;

    function automatic lb_src_e lb_pick_src(input lb_addr_t a);
        return (a == '0) ? LB_SRC_DATA : LB_SRC_ADDR;
    endfunction

    function automatic lb_word_t lb_widen_addr(input lb_addr_t a);
        return {{(LB_DATA_W-LB_ADDR_W){1'b0}}, a};
    endfunction
endpackage

// File: rtl/lb_sync.sv
module lb_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/lb_strobe.sv
module lb_strobe (
    input  logic clk,
    input  logic rst,
    input  logic cs_s,
    input  logic we_s,
    output logic commit
);
    logic we_prev;

    always_ff @(posedge clk) begin
        if (rst) we_prev <= 1'b0;
        else     we_prev <= we_s;
    end

    assign commit = cs_s & we_s & ~we_prev;

    // R5: a held strobe yields one commit, never two in a row
    a_r5_single_commit: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);
endmodule

// File: rtl/lb_store.sv
module lb_store
    import lb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     commit,
    input  lb_addr_t waddr,
    input  lb_word_t wdata,
    output lb_word_t value
);
    lb_src_e  src;
    lb_word_t next_val;

    always_comb begin
        src = lb_pick_src(waddr);
        unique case (src)
            LB_SRC_DATA: next_val = wdata;
            LB_SRC_ADDR: next_val = lb_widen_addr(waddr);
            default:     next_val = wdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         value <= '0;
        else if (commit) value <= next_val;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (value == '0));

    a_r2_data_capture: assert property (@(posedge clk) disable iff (rst)
        (commit && waddr == '0) |=> (value == $past(wdata)));

    a_r3_addr_capture: assert property (@(posedge clk) disable iff (rst)
        (commit && waddr != '0) |=>
            (value[LB_ADDR_W-1:0] == $past(waddr)) &&
            (value[LB_DATA_W-1:LB_ADDR_W] == '0));

    a_r6_hold_value: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(value));
endmodule

// File: rtl/lb_test_reg.sv
module lb_test_reg
    import lb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_cs,
    input  logic                 bus_we,
    input  logic                 bus_oe,
    input  logic [LB_ADDR_W-1:0] bus_addr,
    input  logic [LB_DATA_W-1:0] bus_wdata,
    output logic [LB_DATA_W-1:0] bus_rdata,
    output logic                 bus_rdata_oe
);
    localparam int unsigned BUS_BITS = $bits(lb_bus_t);

    lb_bus_t  raw_bus;
    lb_bus_t  syn_bus;
    logic     commit;
    lb_word_t value;

    assign raw_bus = '{cs: bus_cs, we: bus_we, oe: bus_oe,
                       addr: bus_addr, data: bus_wdata};

    lb_sync #(.WIDTH(BUS_BITS), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_bus),
        .dout (syn_bus)
    );

    lb_strobe strobe_i (
        .clk    (clk),
        .rst    (rst),
        .cs_s   (syn_bus.cs),
        .we_s   (syn_bus.we),
        .commit (commit)
    );

    lb_store store_i (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .waddr  (syn_bus.addr),
        .wdata  (syn_bus.data),
        .value  (value)
    );

    always_comb begin
        bus_rdata_oe = syn_bus.cs & syn_bus.oe;
        bus_rdata    = bus_rdata_oe ? value : '0;
    end

    // R7: pads stay released whenever the synchronized select is low
    a_r7_pads_idle: assert property (@(posedge clk) disable iff (rst)
        !syn_bus.cs |-> (!bus_rdata_oe && bus_rdata == '0));

    // R4: read data tracks the register, not the read address
    a_r4_read_any_addr: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata_oe && $past(bus_rdata_oe) && !$past(commit) && !commit)
            |-> $stable(bus_rdata));
endmodule

// File: tb/lb_test_reg_tb_top.sv
module lb_test_reg_tb_top;
    import lb_pkg::*;

    logic           clk = 1'b0;
    logic           rst;
    logic           bus_cs, bus_we, bus_oe;
    logic [23:0]    bus_addr;
    logic [31:0]    bus_wdata;
    logic [31:0]    bus_rdata;
    logic           bus_rdata_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lb_test_reg dut_i (
        .clk(clk), .rst(rst),
        .bus_cs(bus_cs), .bus_we(bus_we), .bus_oe(bus_oe),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe)
    );

    // {write address, write data, read address, expected readback}
    typedef struct packed {
        logic [23:0] waddr;
        logic [31:0] wdata;
        logic [23:0] raddr;
        logic [31:0] expv;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{24'h000000, 32'hDEADBEEF, 24'h000000, 32'hDEADBEEF},
        '{24'h000000, 32'h00000000, 24'h123456, 32'h00000000},
        '{24'h000000, 32'hFFFFFFFF, 24'hFFFFFF, 32'hFFFFFFFF},
        '{24'h000000, 32'hA5A55A5A, 24'h000001, 32'hA5A55A5A},
        '{24'h000001, 32'hFFFFFFFF, 24'h000000, 32'h00000001},
        '{24'hFFFFFF, 32'h12345678, 24'h000000, 32'h00FFFFFF},
        '{24'h800000, 32'hFFFFFFFF, 24'h7FFFFF, 32'h00800000},
        '{24'h5A5A5A, 32'h00000000, 24'h000000, 32'h005A5A5A},
        '{24'h000000, 32'h80000001, 24'hABCDEF, 32'h80000001},
        '{24'h3C3C3C, 32'hCAFEF00D, 24'h000002, 32'h003C3C3C}
    };

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        wait_neg(5);
        bus_we = 1'b0; bus_cs = 1'b0;
        wait_neg(4);
    endtask

    task automatic do_read(input logic [23:0] a, output logic [31:0] v, output logic en);
        @(negedge clk);
        bus_cs = 1'b1; bus_oe = 1'b1; bus_addr = a;
        wait_neg(5);
        v = bus_rdata; en = bus_rdata_oe;
        bus_cs = 1'b0; bus_oe = 1'b0;
        wait_neg(4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        en;
        rst = 1'b1; bus_cs = 0; bus_we = 0; bus_oe = 0;
        bus_addr = '0; bus_wdata = '0;
        wait_neg(4);
        rst = 1'b0;
        wait_neg(2);

        // R7: idle bus leaves pads released
        check("R7 idle oe", {31'b0, bus_rdata_oe}, 32'h0);
        check("R7 idle data", bus_rdata, 32'h0);

        // R1: reset value
        do_read(24'h000000, v, en);
        check("R1 reset value", v, 32'h0);
        check("R7 read oe", {31'b0, en}, 32'h1);

        // Table walk: R2, R3, R4
        foreach (VECS[i]) begin
            do_write(VECS[i].waddr, VECS[i].wdata);
            do_read(VECS[i].raddr, v, en);
            check(VECS[i].waddr == '0 ? "R2/R4 table" : "R3/R4 table", v, VECS[i].expv);
        end

        // R2: walking one on data lines
        for (int b = 0; b < 32; b++) begin
            do_write(24'h000000, 32'h1 << b);
            do_read(24'h000000, v, en);
            check("R2 walking data", v, 32'h1 << b);
        end

        // R3: walking one on address lines, data all ones must be ignored
        for (int b = 0; b < 24; b++) begin
            do_write(24'h1 << b, 32'hFFFFFFFF);
            do_read(24'h000000, v, en);
            check("R3 walking addr", v, 32'h1 << b);
        end

        // R4: same content read at several addresses
        do_write(24'h000000, 32'h0BADF00D);
        for (int k = 0; k < 4; k++) begin
            do_read(24'h1 << (k * 6), v, en);
            check("R4 any read addr", v, 32'h0BADF00D);
        end

        // R5: held strobe, data and address swapped while held
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 24'h000000; bus_wdata = 32'h11112222;
        wait_neg(6);
        bus_wdata = 32'h33334444;
        wait_neg(6);
        bus_addr = 24'h0000AB;
        wait_neg(6);
        bus_we = 1'b0; bus_cs = 1'b0;
        wait_neg(4);
        do_read(24'h000000, v, en);
        check("R5 single commit", v, 32'h11112222);

        // R6: strobe without select
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b1; bus_addr = 24'h000000; bus_wdata = 32'h99999999;
        wait_neg(6);
        bus_we = 1'b0;
        wait_neg(4);
        do_read(24'h000000, v, en);
        check("R6 no select ignored", v, 32'h11112222);

        // R7: select without output enable keeps pads released
        @(negedge clk);
        bus_cs = 1'b1; bus_oe = 1'b0;
        wait_neg(5);
        check("R7 cs only oe", {31'b0, bus_rdata_oe}, 32'h0);
        check("R7 cs only data", bus_rdata, 32'h0);
        bus_cs = 1'b0; bus_oe = 1'b1;
        wait_neg(5);
        check("R7 oe only oe", {31'b0, bus_rdata_oe}, 32'h0);
        check("R7 oe only data", bus_rdata, 32'h0);
        bus_oe = 1'b0;
        wait_neg(3);

        // R1: reset mid-run clears the stored value
        @(negedge clk); rst = 1'b1;
        wait_neg(3); rst = 1'b0;
        wait_neg(2);
        do_read(24'h000005, v, en);
        check("R1 reset after use", v, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule